// File: doc/BRIEF.md
# Four-Beat Burst Write Capture with Lane Merge

This block sits on the write side of a memory that has separate read and write ports. A write request and its burst address are sampled on a rising clock edge. The data for that burst then arrives over the next two clock cycles as four half-cycle beats: rising edge, falling edge, rising edge, falling edge. Every beat carries one 18-bit word and a two-bit lane enable, one enable bit for each 9-bit lane of that word. The block collects the four beats. Only when the last beat has arrived does it merge the whole burst into its internal array: enabled lanes take the new value and disabled lanes keep what they held.

Writes may start at most every other cycle. A request on the edge right after an accepted request is dropped. Its data is not lost, because on that edge the port is carrying the first beat of the burst already in progress. Because of this spacing, the last two beats of one burst overlap the request and first beat of the next. The block therefore keeps the address of the burst being committed apart from the address of the burst being collected. When a burst is committed, a one-cycle pulse and the committed burst address are driven out for a downstream forwarding check. A combinational readback port exposes any word of the array.

The sequencer has five states:
- IDLE: no burst is pending.
- HEAD: the first beat is due at the next rising edge.
- BODY: beats two and three are due.
- TAIL: the fourth beat is due, and the burst commits at the next rising edge.
- HEAD_TAIL: the burst ahead commits while the first beat of the newer burst is captured.

The transitions are:
- IDLE goes to HEAD on an accepted request and otherwise stays in IDLE.
- HEAD always goes to BODY.
- BODY goes to HEAD_TAIL on an accepted request and otherwise to TAIL.
- TAIL goes to HEAD on an accepted request and otherwise to IDLE.
- HEAD_TAIL always goes to BODY.

Requests are accepted only in IDLE, BODY and TAIL.

Top module: `bwc_burst_write`

## Requirements
- R1: After reset, every array word reads back as zero and `commit_pulse` is low.
- R2: A request (`wr_sel` high at a rising edge while the previous edge accepted none) is committed at the third rising edge after it. `commit_pulse` is high for the cycle after that edge, and `commit_addr` then equals the request's `wr_addr`.
- R3: Beat words are placed by arrival order. The word sampled at the first rising edge after the request goes to index 0, the following falling edge to index 1, the next rising edge to index 2 and the next falling edge to index 3. Readback address = {burst address, 2-bit index}.
- R4: Lane enable bit 0 governs word bits 8:0 and bit 1 governs bits 17:9. A value of 1 writes the incoming lane.
- R5: A lane whose enable bit is 0 keeps its previously stored value through the commit.
- R6: The array does not change before all four beats have been captured. Readback of a burst's words shows the old contents until the commit edge.
- R7: A request on the rising edge right after an accepted request is ignored: it produces no commit pulse and writes nothing at its address.
- R8: Requests on every other rising edge are all accepted. Each burst commits intact with its own address, although its last beats overlap the next burst's request and first beat.
- R9: While `wr_sel` stays low and no burst is pending, data and lane-enable activity changes neither the array nor `commit_pulse`.
- R10: `commit_pulse` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising and falling edges both sample beats |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_sel | input | 1 | Write request, sampled at rising edges |
| wr_addr | input | ADDR_W | Burst address, sampled with the request |
| wr_data | input | 18 | Beat data word |
| wr_lane_en | input | 2 | Per-beat lane enables, 1 = write the lane |
| rd_addr | input | ADDR_W+2 | Readback word address {burst, index} |
| rd_data | output | 18 | Readback word (combinational) |
| commit_pulse | output | 1 | One-cycle pulse after a burst commit |
| commit_addr | output | ADDR_W | Burst address of the last commit |

## Verification
The commit of one burst and the capture of the next burst's first beat land on the same rising edge when requests come every other cycle. On that same edge the previous falling-edge beat is consumed as the older burst's fourth word. The bench provokes this with three requests spaced two cycles apart, each to a different address with distinct words. It judges the result by reading back all twelve words and by matching each commit pulse and its address against a schedule that the bench computes itself. A back-to-back request pair is also driven, to show that the dropped request's beat is taken as data for the burst in flight rather than as a new burst.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int BEATS  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int IDX_W  = $clog2(BEATS);

    typedef struct packed {
        logic [LANES-1:0]  en;
        logic [WORD_W-1:0] data;
    } beat_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL,
        ST_HEAD_TAIL
    } wr_state_e;
endpackage

// File: rtl/bwc_fall_capture.sv
module bwc_fall_capture
    import bwc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t beat_in,
    output beat_t beat_q
);
    // Holds the beat presented at the falling edge for use at the next rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_in;
        end
    end
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
    import bwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_sel,
    output logic accept,
    output logic take_first,
    output logic take_middle,
    output logic commit
);
    wr_state_e state_q, state_d;
    logic      gate_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        gate_open   = 1'b0;
        take_first  = 1'b0;
        take_middle = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_IDLE:      gate_open = 1'b1;
            ST_HEAD:      take_first = 1'b1;
            ST_BODY: begin
                gate_open   = 1'b1;
                take_middle = 1'b1;
            end
            ST_TAIL: begin
                gate_open = 1'b1;
                commit    = 1'b1;
            end
            ST_HEAD_TAIL: begin
                take_first = 1'b1;
                commit     = 1'b1;
            end
            default: gate_open = 1'b0;
        endcase
    end

    assign accept = wr_sel && gate_open;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = accept ? ST_HEAD : ST_IDLE;
            ST_HEAD:      state_d = ST_BODY;
            ST_BODY:      state_d = accept ? ST_HEAD_TAIL : ST_TAIL;
            ST_TAIL:      state_d = accept ? ST_HEAD : ST_IDLE;
            ST_HEAD_TAIL: state_d = ST_BODY;
            default:      state_d = ST_IDLE;
        endcase
    end

    p_gap_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    p_commit_third_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##3 commit);

    p_first_then_middle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_first |=> take_middle);
endmodule

// File: rtl/bwc_assembler.sv
module bwc_assembler
    import bwc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_first,
    input  logic                take_middle,
    input  beat_t               rise_beat,
    input  beat_t               fall_beat,
    output beat_t [BEATS-1:0]   burst
);
    beat_t slot0_q, slot1_q, slot2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
            slot2_q <= '0;
        end else begin
            if (take_first) begin
                slot0_q <= rise_beat;
            end
            if (take_middle) begin
                slot1_q <= fall_beat;
                slot2_q <= rise_beat;
            end
        end
    end

    // The fourth beat is still in the falling-edge holder at the commit edge.
    assign burst[0] = slot0_q;
    assign burst[1] = slot1_q;
    assign burst[2] = slot2_q;
    assign burst[3] = fall_beat;
endmodule

// File: rtl/bwc_store.sv
module bwc_store
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       base,
    input  beat_t [BEATS-1:0]       burst,
    input  logic [ADDR_W+IDX_W-1:0] rd_addr,
    output logic [WORD_W-1:0]       rd_data
);
    localparam int WORDS = (1 << ADDR_W) * BEATS;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] merged [BEATS];
    logic [ADDR_W+IDX_W-1:0] wa [BEATS];

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        assign wa[b] = {base, IDX_W'(b)};
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign merged[b][l*LANE_W +: LANE_W] = burst[b].en[l]
                ? burst[b].data[l*LANE_W +: LANE_W]
                : mem[wa[b]][l*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            for (int b = 0; b < BEATS; b++) begin
                mem[wa[b]] <= merged[b];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    p_lane_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !burst[0].en[0]) |=>
            (mem[$past(wa[0])][LANE_W-1:0] == $past(rd_data_lane0_old)));

    p_no_change_before_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!$stable(rd_addr) || $stable(rd_data)));

    logic [LANE_W-1:0] rd_data_lane0_old;
    assign rd_data_lane0_old = mem[wa[0]][LANE_W-1:0];
endmodule

// File: rtl/bwc_burst_write.sv
module bwc_burst_write
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_sel,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [LANES-1:0]        wr_lane_en,
    input  logic [ADDR_W+IDX_W-1:0] rd_addr,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    commit_pulse,
    output logic [ADDR_W-1:0]       commit_addr
);
    beat_t             rise_beat, fall_beat;
    beat_t [BEATS-1:0] burst;
    logic              accept, take_first, take_middle, commit;
    logic [ADDR_W-1:0] cur_addr_q, fin_addr_q;

    assign rise_beat.en   = wr_lane_en;
    assign rise_beat.data = wr_data;

    bwc_fall_capture u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_in (rise_beat),
        .beat_q  (fall_beat)
    );

    bwc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel      (wr_sel),
        .accept      (accept),
        .take_first  (take_first),
        .take_middle (take_middle),
        .commit      (commit)
    );

    bwc_assembler u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_first  (take_first),
        .take_middle (take_middle),
        .rise_beat   (rise_beat),
        .fall_beat   (fall_beat),
        .burst       (burst)
    );

    // Collecting and committing addresses are kept apart, since bursts overlap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q   <= '0;
            fin_addr_q   <= '0;
            commit_pulse <= 1'b0;
            commit_addr  <= '0;
        end else begin
            if (accept) begin
                cur_addr_q <= wr_addr;
            end
            if (take_middle) begin
                fin_addr_q <= cur_addr_q;
            end
            commit_pulse <= commit;
            if (commit) begin
                commit_addr <= fin_addr_q;
            end
        end
    end

    bwc_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .base    (fin_addr_q),
        .burst   (burst),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> !commit_pulse);

    p_idle_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && !take_first && !take_middle && !commit) |=> !commit);
endmodule

// File: tb/tb_bwc_burst_write.sv
module tb_bwc_burst_write;
    localparam int AW = 4;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [17:0]   wr_data = '0;
    logic [1:0]    wr_lane_en = '0;
    logic [AW+1:0] rd_addr = '0;
    logic [17:0]   rd_data;
    logic          commit_pulse;
    logic [AW-1:0] commit_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit            s_sel [NC];
    logic [AW-1:0] s_addr [NC];
    logic [17:0]   s_rd [NC];
    logic [17:0]   s_fd [NC];
    logic [1:0]    s_rbe [NC];
    logic [1:0]    s_fbe [NC];
    bit            rec_pulse [NC];
    logic [AW-1:0] rec_caddr [NC];
    logic [17:0]   rec_rd [NC];
    logic [17:0]   model [64];

    always #5 clk = ~clk;

    bwc_burst_write #(.ADDR_W(AW)) dut (
        .clk (clk), .rst_n (rst_n), .wr_sel (wr_sel), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_lane_en (wr_lane_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .commit_pulse (commit_pulse), .commit_addr (commit_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_sched();
        for (int c = 0; c < NC; c++) begin
            s_sel[c] = 0; s_addr[c] = '0; s_rd[c] = '0; s_fd[c] = '0;
            s_rbe[c] = 2'b00; s_fbe[c] = 2'b00;
        end
    endtask

    // One call per cycle: the rising edge sees request and rise beat, the falling edge the fall beat.
    task automatic play(input int n, input logic [AW+1:0] probe, input string req);
        bit acc [NC];
        bit prev;
        int k;
        logic [17:0] w [4];
        logic [1:0]  e [4];
        rd_addr = probe;
        for (int c = 0; c < n; c++) begin
            wr_sel = s_sel[c]; wr_addr = s_addr[c];
            wr_data = s_rd[c]; wr_lane_en = s_rbe[c];
            @(posedge clk); #2;
            wr_sel = 1'b0;
            wr_data = s_fd[c]; wr_lane_en = s_fbe[c];
            @(negedge clk); #2;
            rec_pulse[c] = commit_pulse;
            rec_caddr[c] = commit_addr;
            rec_rd[c] = rd_data;
        end
        wr_data = '0; wr_lane_en = '0;
        prev = 0;
        for (int c = 0; c < n; c++) begin
            acc[c] = s_sel[c] && !prev;
            prev = acc[c];
        end
        for (int c = 0; c < n; c++) begin
            bit ep;
            ep = (c >= 3) && acc[c-3];
            chk(rec_pulse[c] == ep, req, $sformatf("commit pulse cycle %0d", c),
                32'(rec_pulse[c]), 32'(ep));
            if (ep) begin
                chk(rec_caddr[c] == s_addr[c-3], req, $sformatf("commit addr cycle %0d", c),
                    32'(rec_caddr[c]), 32'(s_addr[c-3]));
            end
        end
        for (int c = 0; c + 2 < n; c++) begin
            if (acc[c]) begin
                k = c;
                w[0] = s_rd[k+1]; e[0] = s_rbe[k+1];
                w[1] = s_fd[k+1]; e[1] = s_fbe[k+1];
                w[2] = s_rd[k+2]; e[2] = s_rbe[k+2];
                w[3] = s_fd[k+2]; e[3] = s_fbe[k+2];
                for (int b = 0; b < 4; b++) begin
                    int idx;
                    idx = int'(s_addr[k]) * 4 + b;
                    if (e[b][0]) model[idx][8:0]  = w[b][8:0];
                    if (e[b][1]) model[idx][17:9] = w[b][17:9];
                end
            end
        end
    endtask

    task automatic check_burst(input logic [AW-1:0] a, input string req);
        for (int b = 0; b < 4; b++) begin
            rd_addr = {a, 2'(b)};
            #1;
            chk(rd_data == model[{a, 2'(b)}], req, $sformatf("word %0d of burst %0d", b, a),
                32'(rd_data), 32'(model[{a, 2'(b)}]));
        end
    endtask

    task automatic t_reset();
        chk(commit_pulse == 1'b0, "R1", "pulse after reset", 32'(commit_pulse), 0);
        for (int i = 0; i < 64; i += 9) begin
            rd_addr = 6'(i);
            #1;
            chk(rd_data == 18'h0, "R1", $sformatf("word %0d after reset", i), 32'(rd_data), 0);
        end
    endtask

    // R2, R3, R4, R6: full burst with all lanes enabled; probe word 0 across the run.
    task automatic t_single();
        logic [17:0] old_w;
        clear_sched();
        s_sel[0] = 1; s_addr[0] = 4'd5;
        s_rd[1] = 18'h11111; s_rbe[1] = 2'b11;
        s_fd[1] = 18'h22222; s_fbe[1] = 2'b11;
        s_rd[2] = 18'h33333; s_rbe[2] = 2'b11;
        s_fd[2] = 18'h04444; s_fbe[2] = 2'b11;
        old_w = model[5*4];
        play(6, {4'd5, 2'd0}, "R2");
        for (int c = 0; c < 3; c++) begin
            chk(rec_rd[c] == old_w, "R6", $sformatf("word unchanged before commit cycle %0d", c),
                32'(rec_rd[c]), 32'(old_w));
        end
        chk(rec_rd[3] == 18'h11111, "R6", "word updated at commit", 32'(rec_rd[3]), 32'h11111);
        check_burst(4'd5, "R3");
    endtask

    // R4, R5: mixed lane enables over the burst written above.
    task automatic t_partial();
        clear_sched();
        s_sel[0] = 1; s_addr[0] = 4'd5;
        s_rd[1] = 18'h2AAAA; s_rbe[1] = 2'b01;
        s_fd[1] = 18'h15555; s_fbe[1] = 2'b10;
        s_rd[2] = 18'h3FFFF; s_rbe[2] = 2'b00;
        s_fd[2] = 18'h00F0F; s_fbe[2] = 2'b11;
        play(5, '0, "R4");
        check_burst(4'd5, "R5");
    endtask

    // R7: second request on the next edge is dropped.
    task automatic t_back_to_back();
        clear_sched();
        s_sel[0] = 1; s_addr[0] = 4'd2;
        s_sel[1] = 1; s_addr[1] = 4'd9;
        s_rd[1] = 18'h0ABCD; s_rbe[1] = 2'b11;
        s_fd[1] = 18'h1BCDE; s_fbe[1] = 2'b11;
        s_rd[2] = 18'h2CDEF; s_rbe[2] = 2'b11;
        s_fd[2] = 18'h3DEF0; s_fbe[2] = 2'b11;
        s_rd[3] = 18'h3FFFF; s_rbe[3] = 2'b11;
        s_fd[3] = 18'h3FFFF; s_fbe[3] = 2'b11;
        play(7, '0, "R7");
        check_burst(4'd2, "R7");
        check_burst(4'd9, "R7");
    endtask

    // R8, R10: requests every other edge, commit of one burst overlaps capture of the next.
    task automatic t_alternate();
        clear_sched();
        s_sel[0] = 1; s_addr[0] = 4'd3;
        s_sel[2] = 1; s_addr[2] = 4'd4;
        s_sel[4] = 1; s_addr[4] = 4'd6;
        for (int c = 1; c <= 6; c++) begin
            s_rd[c] = 18'h01000 + 18'(c * 18'h111);
            s_fd[c] = 18'h20000 + 18'(c * 18'h222);
            s_rbe[c] = 2'b11; s_fbe[c] = 2'b11;
        end
        play(9, '0, "R8");
        chk(rec_pulse[4] == 1'b0, "R10", "pulse low between commits", 32'(rec_pulse[4]), 0);
        chk(rec_pulse[6] == 1'b0, "R10", "pulse low after second commit", 32'(rec_pulse[6]), 0);
        check_burst(4'd3, "R8");
        check_burst(4'd4, "R8");
        check_burst(4'd6, "R8");
    endtask

    // R9: data activity with the port deselected.
    task automatic t_deselect();
        clear_sched();
        for (int c = 0; c < 8; c++) begin
            s_addr[c] = 4'(c);
            s_rd[c] = 18'h3A5A5 ^ 18'(c);
            s_fd[c] = 18'h05A5A ^ 18'(c);
            s_rbe[c] = 2'b11; s_fbe[c] = 2'b11;
        end
        play(8, '0, "R9");
        check_burst(4'd5, "R9");
        check_burst(4'd0, "R9");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_single();
        t_partial();
        t_back_to_back();
        t_alternate();
        t_deselect();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule